// File: doc/BRIEF.md
# Serial ASCII Register Command Bridge

This block lets a terminal or a test host reach a 16-bit register space over a plain asynchronous serial line. It receives text commands, turns the hexadecimal address and data fields into binary, and runs exactly one single-beat access per command on a Wishbone-style master port. A write command changes the addressed register and sends no answer. A read command answers with the register value as text.

The line uses 8 data bits, no parity and two stop bits. One parameter sets the bit period as a multiple of sixteen clock cycles. After reset the block announces itself with a short banner. It ignores the line until the banner has gone out. While a bus access or a read reply is in progress, it also ignores incoming bytes.

Top module: `uart_regbridge`

## Requirements
- R1: The `txd` output idles high. Each character goes out as one low start bit, then 8 data bits with the least significant bit first, then two high stop bits. Every bit lasts (PRESC+1)*16 clock cycles.
- R2: The receiver samples each bit at its midpoint. A low pulse on `rxd` that has returned high by half a bit period after it began is not taken as a start bit and produces no character.
- R3: After reset the block sends the seven bytes "READY", 0x0D, 0x0A. Bytes that arrive while this banner is being sent are discarded and never form part of a command.
- R4: The 12-character command 'W', space, four hex address digits, space, four hex data digits, space produces one write access. The access carries `bus_we`=1 and the given address and data, most significant digit first.
- R5: The 7-character command 'R', space, four hex address digits, space produces one read access with `bus_we`=0. The reply is the returned 16-bit value as four uppercase hex digits, most significant first, followed by 0x0D 0x0A. A write sends no reply.
- R6: The hex digits 'a' to 'f' are accepted and have the same value as 'A' to 'F'.
- R7: A command with an unknown leading letter, a non-hex digit or a missing space is discarded without any bus access. The next command is then parsed normally.
- R8: `bus_cyc` and `bus_stb` stay high, with `bus_adr`, `bus_we` and `bus_wdat` stable, until `bus_ack` is sampled high. Both strobes are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial command input, idle high |
| txd | output | 1 | Serial reply output, idle high |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe, equal to the cycle signal |
| bus_we | output | 1 | Write enable of the current access |
| bus_adr | output | 16 | Register address |
| bus_wdat | output | 16 | Write data |
| bus_rdat | input | 16 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Access acknowledge from the register side |

## Verification
The handshake properties assume that the register side raises `bus_ack` only while `bus_cyc` is high, and for one cycle per access. The bench slave acknowledges a fixed number of cycles after it sees the strobe, then drops the acknowledge on the next falling edge. The serial checks assume frames that keep the stated bit period. The bench sender derives every bit time from the same prescaler as the design. The only deliberate violation it applies is a short low glitch, which must be rejected.

// File: rtl/uart_regbridge.sv
module uart_regbridge #(
  parameter int PRESC = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rxd,
  output logic        txd,
  output logic        bus_cyc,
  output logic        bus_stb,
  output logic        bus_we,
  output logic [15:0] bus_adr,
  output logic [15:0] bus_wdat,
  input  logic [15:0] bus_rdat,
  input  logic        bus_ack
);
  localparam int BITC = (PRESC + 1) * 16;
  localparam int HALF = BITC / 2;
  localparam int CW   = $clog2(BITC);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_e;
  typedef enum logic [2:0] {P_CMD, P_SP1, P_ADR, P_SP2, P_DAT, P_SP3} ps_e;

  // receiver
  logic [1:0]    rsync;
  rx_e           rstate;
  logic [CW-1:0] rcnt;
  logic [2:0]    rbit;
  logic [7:0]    rsh;
  logic          rvld;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsync <= 2'b11; rstate <= R_IDLE; rcnt <= '0; rbit <= '0; rsh <= '0; rvld <= 1'b0;
    end else begin
      rsync <= {rsync[0], rxd};
      rvld  <= 1'b0;
      if (rstate == R_IDLE) begin
        if (!rsync[1]) begin
          rcnt   <= CW'(HALF - 1);
          rstate <= R_START;
        end
      end else if (rcnt != '0) begin
        rcnt <= rcnt - 1'b1;
      end else begin
        rcnt <= CW'(BITC - 1);
        case (rstate)
          R_START: begin
            rbit   <= '0;
            rstate <= rsync[1] ? R_IDLE : R_DATA;
          end
          R_DATA: begin
            rsh  <= {rsync[1], rsh[7:1]};
            rbit <= rbit + 1'b1;
            if (rbit == 3'd7) rstate <= R_STOP;
          end
          default: begin
            rvld   <= rsync[1];
            rstate <= R_IDLE;
          end
        endcase
      end
    end
  end

  // parser and bus master
  function automatic logic [4:0] hexval(input logic [7:0] c);
    if (c >= "0" && c <= "9") return {1'b1, 4'(c - 8'd48)};
    if (c >= "A" && c <= "F") return {1'b1, 4'(c - 8'd55)};
    if (c >= "a" && c <= "f") return {1'b1, 4'(c - 8'd87)};
    return 5'd0;
  endfunction

  ps_e         pst;
  logic        is_wr, cyc_q, msg_act;
  logic [1:0]  dig;
  logic [15:0] adr_q, dat_q, rd_q;
  logic [4:0]  hx;
  logic        sp, take, rd_done;

  assign hx      = hexval(rsh);
  assign sp      = (rsh == " ");
  assign take    = rvld && !msg_act && !cyc_q;
  assign rd_done = cyc_q && bus_ack && !is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pst <= P_CMD; is_wr <= 1'b0; cyc_q <= 1'b0; dig <= '0;
      adr_q <= '0; dat_q <= '0; rd_q <= '0;
    end else begin
      if (cyc_q && bus_ack) begin
        cyc_q <= 1'b0;
        if (!is_wr) rd_q <= bus_rdat;
      end
      if (take) begin
        case (pst)
          P_CMD: if (rsh == "W" || rsh == "R") begin
            is_wr <= (rsh == "W");
            pst   <= P_SP1;
          end
          P_SP1: begin
            dig <= '0;
            pst <= sp ? P_ADR : P_CMD;
          end
          P_ADR: if (hx[4]) begin
            adr_q <= {adr_q[11:0], hx[3:0]};
            dig   <= dig + 1'b1;
            if (dig == 2'd3) pst <= P_SP2;
          end else pst <= P_CMD;
          P_SP2: begin
            dig <= '0;
            if (!sp) pst <= P_CMD;
            else if (is_wr) pst <= P_DAT;
            else begin pst <= P_CMD; cyc_q <= 1'b1; end
          end
          P_DAT: if (hx[4]) begin
            dat_q <= {dat_q[11:0], hx[3:0]};
            dig   <= dig + 1'b1;
            if (dig == 2'd3) pst <= P_SP3;
          end else pst <= P_CMD;
          default: begin
            pst <= P_CMD;
            if (sp) cyc_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign bus_cyc  = cyc_q;
  assign bus_stb  = cyc_q;
  assign bus_we   = cyc_q && is_wr;
  assign bus_adr  = adr_q;
  assign bus_wdat = dat_q;

  // transmitter and message sequencer
  logic          msg_ban, tbusy;
  logic [2:0]    midx, mlast;
  logic [CW-1:0] tcnt;
  logic [3:0]    tbit, nib;
  logic [10:0]   tsh;
  logic [7:0]    ch;

  always_comb begin
    case (midx[1:0])
      2'd0:    nib = rd_q[15:12];
      2'd1:    nib = rd_q[11:8];
      2'd2:    nib = rd_q[7:4];
      default: nib = rd_q[3:0];
    endcase
    if (msg_ban) begin
      case (midx)
        3'd0:    ch = "R";
        3'd1:    ch = "E";
        3'd2:    ch = "A";
        3'd3:    ch = "D";
        3'd4:    ch = "Y";
        3'd5:    ch = 8'h0d;
        default: ch = 8'h0a;
      endcase
    end else if (midx < 3'd4) begin
      ch = (nib < 4'd10) ? 8'd48 + 8'(nib) : 8'd55 + 8'(nib);
    end else begin
      ch = (midx == 3'd4) ? 8'h0d : 8'h0a;
    end
  end

  assign mlast = msg_ban ? 3'd6 : 3'd5;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_act <= 1'b1; msg_ban <= 1'b1; midx <= '0;
      tbusy <= 1'b0; tcnt <= '0; tbit <= '0; tsh <= '1;
    end else if (!tbusy) begin
      if (msg_act) begin
        tbusy <= 1'b1;
        tsh   <= {2'b11, ch, 1'b0};
        tcnt  <= CW'(BITC - 1);
        tbit  <= '0;
      end else if (rd_done) begin
        msg_act <= 1'b1;
        msg_ban <= 1'b0;
        midx    <= '0;
      end
    end else if (tcnt != '0) begin
      tcnt <= tcnt - 1'b1;
    end else begin
      tcnt <= CW'(BITC - 1);
      tsh  <= {1'b1, tsh[10:1]};
      tbit <= tbit + 1'b1;
      if (tbit == 4'd10) begin
        tbusy <= 1'b0;
        midx  <= midx + 1'b1;
        if (midx == mlast) msg_act <= 1'b0;
      end
    end
  end

  assign txd = tbusy ? tsh[0] : 1'b1;

  p_stop_r1: assert property (@(posedge clk) disable iff (rst)
    tbusy && tbit >= 4'd9 |-> txd);
  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    msg_act |-> !bus_cyc);
  p_reply_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_act) |-> !msg_ban && $past(bus_cyc && bus_ack && !bus_we));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && !bus_ack |=> bus_cyc && $stable(bus_adr) && $stable(bus_we) && $stable(bus_wdat));
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && bus_ack |=> !bus_cyc && !bus_stb);
endmodule

// File: tb/test_uart_regbridge.sv
module test_uart_regbridge;
  localparam int P    = 1;
  localparam int BITC = (P + 1) * 16;
  localparam int HALF = BITC / 2;
  localparam int LAT  = 3;
  localparam int CHT  = 11 * BITC;
  // {is_write, address, data}
  localparam logic [32:0] VEC [9] = '{
    {1'b1, 16'h8000, 16'h8003}, {1'b1, 16'h8001, 16'h0011},
    {1'b1, 16'h8006, 16'hC5C0}, {1'b1, 16'h8007, 16'hBABE},
    {1'b1, 16'h8004, 16'h9ABC}, {1'b0, 16'h8006, 16'h0000},
    {1'b0, 16'h8007, 16'h0000}, {1'b0, 16'h8001, 16'h0000},
    {1'b0, 16'h8004, 16'h0000}};

  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1, ack = 1'b0;
  logic [15:0] rdat = '0;
  logic txd, cyc, stb, we;
  logic [15:0] adr, wdat;

  uart_regbridge #(.PRESC(P)) i_uart_regbridge (
    .clk(clk), .rst(rst), .rxd(rxd), .txd(txd),
    .bus_cyc(cyc), .bus_stb(stb), .bus_we(we), .bus_adr(adr),
    .bus_wdat(wdat), .bus_rdat(rdat), .bus_ack(ack));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // register slave
  logic [15:0] mem [16];
  logic [15:0] cap_adr = '0, cap_wdat = '0;
  logic        cap_we = 1'b0;
  int          n_acc = 0;
  initial begin
    int wc;
    wc = 0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0;
        chk(cyc === 1'b0 && stb === 1'b0, "R8", "strobe after ack",
            $sformatf("%b", cyc), "0");
      end else if (cyc === 1'b1) begin
        wc++;
        if (wc == LAT) begin
          wc = 0; ack = 1'b1; n_acc++;
          cap_adr = adr; cap_wdat = wdat; cap_we = we;
          if (we) mem[adr[3:0]] = wdat;
          rdat = mem[adr[3:0]];
        end
      end
    end
  end

  // serial receiver of the reply line
  logic [7:0] rbuf [64];
  int rx_n = 0;
  initial begin
    logic [7:0] b;
    logic s1;
    forever begin
      @(negedge txd);
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BITC) @(negedge clk);
        b[i] = txd;
      end
      repeat (BITC) @(negedge clk);
      s1 = txd;
      repeat (BITC) @(negedge clk);
      chk(s1 === 1'b1 && txd === 1'b1, "R1", "two stop bits",
          $sformatf("%b%b", s1, txd), "11");
      rbuf[rx_n % 64] = b;
      rx_n++;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    logic [10:0] f;
    f = {2'b11, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = f[i];
      repeat (BITC) @(negedge clk);
    end
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  function automatic string hex4(input logic [15:0] v);
    string s;
    s = "";
    for (int i = 3; i >= 0; i--) begin
      logic [3:0] n;
      n = v[i*4 +: 4];
      s = {s, $sformatf("%c", (n < 10) ? 8'd48 + 8'(n) : 8'd55 + 8'(n))};
    end
    return s;
  endfunction

  function automatic string got_str(input int from, input int cnt);
    string s;
    s = "";
    for (int i = 0; i < cnt; i++) s = {s, $sformatf("%c", rbuf[(from + i) % 64])};
    return s;
  endfunction

  task automatic wait_rx(input int n);
    for (int i = 0; i < 30000 && rx_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_acc(input int n);
    for (int i = 0; i < 30000 && n_acc < n; i++) @(negedge clk);
  endtask

  task automatic check_reply(input int rx0, input logic [15:0] v, input string req);
    string g, e;
    wait_rx(rx0 + 6);
    g = got_str(rx0, 6);
    e = {hex4(v), "\r\n"};
    chk(rx_n == rx0 + 6 && g == e, req, "read reply", g, e);
  endtask

  logic [15:0] exp_mem [16];

  initial begin
    int acc0, rx0;
    for (int i = 0; i < 16; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1", "txd idle in reset", $sformatf("%b", txd), "1");
    chk(cyc === 1'b0, "R8", "no cycle in reset", $sformatf("%b", cyc), "0");
    rst = 1'b0;

    // R3: fragment sent during the banner must be dropped
    send_str("R 0");
    wait_rx(7);
    chk(got_str(0, 7) == "READY\r\n", "R3", "banner", got_str(0, 7), "READY\\r\\n");
    send_str("001 ");
    repeat (3 * CHT) @(negedge clk);
    chk(n_acc == 0, "R3", "access from banner-time bytes", $sformatf("%0d", n_acc), "0");

    // vector table: writes then readbacks
    for (int k = 0; k < 9; k++) begin
      logic w;
      logic [15:0] a, d;
      {w, a, d} = VEC[k];
      acc0 = n_acc; rx0 = rx_n;
      if (w) begin
        send_str({"W ", hex4(a), " ", hex4(d), " "});
        wait_acc(acc0 + 1);
        chk(cap_we && cap_adr == a && cap_wdat == d, "R4", "write access",
            $sformatf("%b %h %h", cap_we, cap_adr, cap_wdat),
            $sformatf("1 %h %h", a, d));
        exp_mem[a[3:0]] = d;
        repeat (2 * CHT) @(negedge clk);
        chk(rx_n == rx0, "R5", "no reply to write", $sformatf("%0d", rx_n - rx0), "0");
      end else begin
        send_str({"R ", hex4(a), " "});
        wait_acc(acc0 + 1);
        chk(!cap_we && cap_adr == a, "R5", "read access",
            $sformatf("%b %h", cap_we, cap_adr), $sformatf("0 %h", a));
        check_reply(rx0, exp_mem[a[3:0]], "R5");
      end
    end

    // R6: lowercase digits
    acc0 = n_acc; rx0 = rx_n;
    send_str("W 00ab c5c0 ");
    wait_acc(acc0 + 1);
    chk(cap_adr == 16'h00AB && cap_wdat == 16'hC5C0, "R6", "lowercase write",
        $sformatf("%h %h", cap_adr, cap_wdat), "00ab c5c0");
    repeat (CHT) @(negedge clk);
    rx0 = rx_n;
    send_str("R 00Ab ");
    check_reply(rx0, 16'hC5C0, "R6");

    // R7: malformed commands
    acc0 = n_acc;
    send_str("X 1234 ");
    send_str("W 12G4 0000 ");
    send_str("R8006 ");
    repeat (3 * CHT) @(negedge clk);
    chk(n_acc == acc0, "R7", "access from malformed", $sformatf("%0d", n_acc - acc0), "0");
    rx0 = rx_n;
    send_str("R 8006 ");
    check_reply(rx0, 16'hC5C0, "R7");

    // R2: short glitch between command characters
    rx0 = rx_n;
    send_byte("R");
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    send_str(" 8007 ");
    check_reply(rx0, 16'hBABE, "R2");

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule